// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame should be kept, using only its 48-bit destination address. A table of sixteen programmable station addresses is searched for an exact match first. When no valid entry matches, the block falls back to an imperfect hash filter: twelve bits taken from the two last address bytes index a 4096-bit table, and a set bit there means the frame is wanted. Frames accepted by the hash path are tallied in a saturating counter.

Software loads the station entries, the hash table and a small control word through a single-cycle register write port. The receive path presents each destination address together with a one-cycle strobe; one clock later the block returns a valid pulse and an accept flag. Reception is gated by link state, the bus-master enable and a receive-enable bit; when any of them is low every frame is refused. A two-state machine sequences the result: `ST_IDLE` (no result pending) moves to `ST_REPORT` on a strobe (transition "lookup issued"); `ST_REPORT` stays in `ST_REPORT` on a back-to-back strobe ("lookup chained") and returns to `ST_IDLE` otherwise ("result retired").

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset no result is pending, the hash counter reads zero, every station entry is invalid and every hash table bit is clear, so any lookup is rejected.
- R2: A result (`res_valid_o` high for one cycle) appears exactly one clock after each cycle in which `dst_vld_i` is high, and at no other time; `res_accept_o` is high only together with `res_valid_o`.
- R3: Destination byte k is `dst_addr_i[8k+7:8k]`. Station entry n uses write address 2n for its low word, holding bytes 0..3 little-endian (byte 0 in bits 7:0), and 2n+1 for its high word, holding byte 4 in bits 7:0, byte 5 in bits 15:0's upper half and the valid flag in bit 31. A valid entry equal to all six bytes accepts the frame, for every entry 0..15.
- R4: An entry whose valid flag is clear never matches, even if its address bytes are equal.
- R5: Without an exact match, the value {byte5, byte4} is shifted right by 4, 3, 2 or 0 for hash mode 0, 1, 2 or 3, and the low 12 bits form the hash index. The control word is at write address 0x40: bit 0 is receive enable, bits 2:1 the hash mode.
- R6: Hash index bits 11:5 pick table word w, written at address 0x80+w; bits 4:0 pick the bit in it. A set bit accepts the frame, a clear bit rejects it.
- R7: The counter `mc_count_o` increments by one for each frame accepted through the hash path only; exact-match acceptances and rejections leave it unchanged.
- R8: The counter stops at all-ones and does not wrap.
- R9: When `link_up_i`, `bus_master_i` or receive enable is low, every frame is rejected and the counter does not move.
- R10: A register write in the same cycle as a strobe affects lookups from the next strobe on, not the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en_i | input | 1 | Register write strobe |
| cfg_wr_addr_i | input | 8 | Register word address |
| cfg_wr_data_i | input | 32 | Register write data |
| link_up_i | input | 1 | Link is up |
| bus_master_i | input | 1 | Bus-master operation permitted |
| dst_vld_i | input | 1 | Destination address strobe |
| dst_addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid_o | output | 1 | Result pulse, one cycle after the strobe |
| res_accept_o | output | 1 | Frame accepted (meaningful with res_valid_o) |
| mc_count_o | output | CNT_W | Saturating count of hash-path acceptances |

## Verification
The checker watches, every cycle, the one-clock spacing between strobe and result pulse, that acceptance never comes without a result, that a blocked receive path never accepts, and that the counter only moves after a lookup, never after an exact hit, never falls and holds at all-ones. What those properties cannot show is whether the right frames are chosen: the byte packing of station entries, the four hash-mode bit windows, the word and bit selection in the table, and the write-versus-lookup ordering are shown only by the directed scenarios, which compare against values worked out from the requirements.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_W      = 48;
    localparam int WORD_W      = 32;
    localparam int REG_ADDR_W  = 8;
    localparam int HASH_IDX_W  = 12;
    localparam int HASH_BIT_W  = 5;
    localparam int HASH_WORDS  = 1 << (HASH_IDX_W - HASH_BIT_W);
    localparam int VALID_BIT   = 31;

    // register map
    localparam logic [REG_ADDR_W-1:0] CTL_ADDR = 8'h40;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rxf_state_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       rx_en;
    } rxf_ctl_t;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [REG_ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [N_ENT-1:0][WORD_W-1:0]  sta_lo,
    output logic [N_ENT-1:0][WORD_W-1:0]  sta_hi,
    output logic [HASH_WORDS-1:0][WORD_W-1:0] hash_tbl,
    output rxf_ctl_t                      ctl
);

    localparam int ENT_IDX_W = $clog2(N_ENT);
    localparam int STA_SPAN_W = ENT_IDX_W + 1;
    localparam int HW_IDX_W  = $clog2(HASH_WORDS);

    logic                 sta_sel;
    logic                 hash_sel;
    logic                 ctl_sel;
    logic [ENT_IDX_W-1:0] ent_idx;
    logic [HW_IDX_W-1:0]  hw_idx;

    always_comb begin
        sta_sel  = wr_en && (wr_addr[REG_ADDR_W-1:STA_SPAN_W] == '0);
        hash_sel = wr_en && wr_addr[REG_ADDR_W-1];
        ctl_sel  = wr_en && (wr_addr == CTL_ADDR);
        ent_idx  = wr_addr[STA_SPAN_W-1:1];
        hw_idx   = wr_addr[HW_IDX_W-1:0];
    end

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_sta
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sta_lo[g] <= '0;
                    sta_hi[g] <= '0;
                end else if (sta_sel && (ent_idx == ENT_IDX_W'(g))) begin
                    if (wr_addr[0]) begin
                        sta_hi[g] <= wr_data;
                    end else begin
                        sta_lo[g] <= wr_data;
                    end
                end
            end
        end

        for (g = 0; g < HASH_WORDS; g++) begin : g_hash
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hash_tbl[g] <= '0;
                end else if (hash_sel && (hw_idx == HW_IDX_W'(g))) begin
                    hash_tbl[g] <= wr_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (ctl_sel) begin
            ctl.rx_en <= wr_data[0];
            ctl.mode  <= wr_data[2:1];
        end
    end

endmodule

// File: rtl/rxf_exact_match.sv
module rxf_exact_match
    import rxf_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic [ADDR_W-1:0]            dst,
    input  logic [N_ENT-1:0][WORD_W-1:0] sta_lo,
    input  logic [N_ENT-1:0][WORD_W-1:0] sta_hi,
    output logic                         hit
);

    localparam int HI_BYTES_W = ADDR_W - WORD_W;

    logic [N_ENT-1:0] ent_hit;

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_cmp
            always_comb begin
                ent_hit[g] = sta_hi[g][VALID_BIT]
                          && (sta_lo[g] == dst[WORD_W-1:0])
                          && (sta_hi[g][HI_BYTES_W-1:0] == dst[ADDR_W-1:WORD_W]);
            end
        end
    endgenerate

    assign hit = |ent_hit;

endmodule

// File: rtl/rxf_hash_lookup.sv
module rxf_hash_lookup
    import rxf_pkg::*;
(
    input  logic [ADDR_W-1:0]                 dst,
    input  logic [1:0]                        mode,
    input  logic [HASH_WORDS-1:0][WORD_W-1:0] hash_tbl,
    output logic                              hit
);

    localparam int HW_IDX_W = HASH_IDX_W - HASH_BIT_W;

    logic [15:0]            top_bytes;
    logic [HASH_IDX_W-1:0]  idx;
    logic [WORD_W-1:0]      sel_word;

    always_comb begin
        top_bytes = dst[ADDR_W-1:ADDR_W-16];
        unique case (mode)
            2'd0:    idx = top_bytes[15:4];
            2'd1:    idx = top_bytes[14:3];
            2'd2:    idx = top_bytes[13:2];
            default: idx = top_bytes[11:0];
        endcase
        sel_word = hash_tbl[idx[HASH_IDX_W-1:HASH_BIT_W]];
        hit      = sel_word[idx[HASH_BIT_W-1:0]];
    end

    logic unused_ok;
    assign unused_ok = ^{HW_IDX_W};

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
    import rxf_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int CNT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en_i,
    input  logic [REG_ADDR_W-1:0]  cfg_wr_addr_i,
    input  logic [WORD_W-1:0]      cfg_wr_data_i,
    input  logic                   link_up_i,
    input  logic                   bus_master_i,
    input  logic                   dst_vld_i,
    input  logic [ADDR_W-1:0]      dst_addr_i,
    output logic                   res_valid_o,
    output logic                   res_accept_o,
    output logic [CNT_W-1:0]       mc_count_o
);

    logic [N_ENT-1:0][WORD_W-1:0]      sta_lo;
    logic [N_ENT-1:0][WORD_W-1:0]      sta_hi;
    logic [HASH_WORDS-1:0][WORD_W-1:0] hash_tbl;
    rxf_ctl_t                          ctl;
    logic                              ctl_rx_en;
    logic                              exact_any;
    logic                              hash_any;
    logic                              rx_ready;
    logic                              accept_now;
    logic                              hash_take;
    logic                              accept_q;
    rxf_state_e                        state_q;
    rxf_state_e                        state_d;

    rxf_cfg_regs #(.N_ENT(N_ENT)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en_i),
        .wr_addr  (cfg_wr_addr_i),
        .wr_data  (cfg_wr_data_i),
        .sta_lo   (sta_lo),
        .sta_hi   (sta_hi),
        .hash_tbl (hash_tbl),
        .ctl      (ctl)
    );

    rxf_exact_match #(.N_ENT(N_ENT)) exact_i (
        .dst    (dst_addr_i),
        .sta_lo (sta_lo),
        .sta_hi (sta_hi),
        .hit    (exact_any)
    );

    rxf_hash_lookup hash_i (
        .dst      (dst_addr_i),
        .mode     (ctl.mode),
        .hash_tbl (hash_tbl),
        .hit      (hash_any)
    );

    always_comb begin
        ctl_rx_en  = ctl.rx_en;
        rx_ready   = link_up_i && bus_master_i && ctl_rx_en;
        accept_now = rx_ready && (exact_any || hash_any);
        hash_take  = rx_ready && !exact_any && hash_any;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = dst_vld_i ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = dst_vld_i ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // decision capture and hash counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_q   <= 1'b0;
            mc_count_o <= '0;
        end else if (dst_vld_i) begin
            accept_q <= accept_now;
            if (hash_take && (mc_count_o != {CNT_W{1'b1}})) begin
                mc_count_o <= mc_count_o + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        res_valid_o  = 1'b0;
        res_accept_o = 1'b0;
        unique case (state_q)
            ST_REPORT: begin
                res_valid_o  = 1'b1;
                res_accept_o = accept_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rxf_addr_filter_chk.sv
module rxf_addr_filter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dst_vld_i,
    input logic             link_up_i,
    input logic             bus_master_i,
    input logic             ctl_rx_en,
    input logic             exact_any,
    input logic             res_valid_o,
    input logic             res_accept_o,
    input logic [CNT_W-1:0] mc_count_o
);

    // R2
    result_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_vld_i |=> res_valid_o);

    // R2
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_vld_i |=> !res_valid_o);

    // R2
    accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept_o |-> res_valid_o);

    // R9
    blocked_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_vld_i && !(link_up_i && bus_master_i && ctl_rx_en)) |=> !res_accept_o);

    // R9
    blocked_count_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up_i && bus_master_i && ctl_rx_en) |=> $stable(mc_count_o));

    // R7
    count_idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_vld_i |=> $stable(mc_count_o));

    // R7
    exact_not_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_vld_i && exact_any) |=> $stable(mc_count_o));

    // R8
    count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_count_o == {CNT_W{1'b1}}) |=> (mc_count_o == {CNT_W{1'b1}}));

    // R8
    count_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mc_count_o >= $past(mc_count_o)));

endmodule

bind rxf_addr_filter rxf_addr_filter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dst_vld_i    (dst_vld_i),
    .link_up_i    (link_up_i),
    .bus_master_i (bus_master_i),
    .ctl_rx_en    (ctl_rx_en),
    .exact_any    (exact_any),
    .res_valid_o  (res_valid_o),
    .res_accept_o (res_accept_o),
    .mc_count_o   (mc_count_o)
);

// File: tb/rxf_addr_filter_tb_top.sv
module rxf_addr_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en_i = 1'b0;
    logic [7:0]  cfg_wr_addr_i = '0;
    logic [31:0] cfg_wr_data_i = '0;
    logic        link_up_i = 1'b1;
    logic        bus_master_i = 1'b1;
    logic        dst_vld_i = 1'b0;
    logic [47:0] dst_addr_i = '0;
    logic        res_valid_o;
    logic        res_accept_o;
    logic [CNT_W-1:0] mc_count_o;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    logic got_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxf_addr_filter #(.N_ENT(16), .CNT_W(CNT_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en_i   (cfg_wr_en_i),
        .cfg_wr_addr_i (cfg_wr_addr_i),
        .cfg_wr_data_i (cfg_wr_data_i),
        .link_up_i     (link_up_i),
        .bus_master_i  (bus_master_i),
        .dst_vld_i     (dst_vld_i),
        .dst_addr_i    (dst_addr_i),
        .res_valid_o   (res_valid_o),
        .res_accept_o  (res_accept_o),
        .mc_count_o    (mc_count_o)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en_i   = 1'b1;
        cfg_wr_addr_i = a;
        cfg_wr_data_i = d;
        @(negedge clk);
        cfg_wr_en_i   = 1'b0;
    endtask

    task automatic set_station(input int n, input logic [47:0] mac, input logic vld);
        wr(8'(2*n), mac[31:0]);
        wr(8'(2*n+1), {vld, 15'd0, mac[47:32]});
    endtask

    task automatic set_ctl(input logic en, input logic [1:0] mode);
        wr(8'h40, {29'd0, mode, en});
    endtask

    // strobe one address; result sampled at the next falling edge
    task automatic lookup(input logic [47:0] mac, output logic acc);
        @(negedge clk);
        dst_vld_i  = 1'b1;
        dst_addr_i = mac;
        @(negedge clk);
        dst_vld_i  = 1'b0;
        checks++;
        if (res_valid_o !== 1'b1) begin
            errors++;
            $display("FAIL R2 valid after strobe: actual %b expected 1", res_valid_o);
        end
        acc = res_accept_o;
    endtask

    function automatic int hash_idx(input logic [47:0] mac, input int mode);
        int v;
        int sh;
        v = {mac[47:40], mac[39:32]};
        sh = (mode == 0) ? 4 : (mode == 1) ? 3 : (mode == 2) ? 2 : 0;
        return (v >> sh) & 12'hfff;
    endfunction

    function automatic int sat(input int v);
        return (v > int'(CNT_MAX)) ? int'(CNT_MAX) : v;
    endfunction

    localparam logic [47:0] MAC_A = 48'h6655_4433_2211;
    localparam logic [47:0] MAC_B = 48'hab01_cd02_ef03;
    localparam logic [47:0] MAC_C = 48'h0f0e_0d0c_0b0a;
    localparam logic [47:0] MAC_D = 48'h1234_5678_9abc;
    localparam logic [47:0] MAC_H = 48'h3ca7_105e_0001;

    task automatic t_reset;
        @(negedge clk);
        check("R1", "valid after reset", res_valid_o, 0);
        check("R1", "count after reset", mc_count_o, 0);
        set_ctl(1'b1, 2'd0);
        lookup(MAC_A, got_acc);
        check("R1", "station table empty", got_acc, 0);
        lookup(MAC_H, got_acc);
        check("R1", "hash table empty", got_acc, 0);
        check("R1", "count unchanged", mc_count_o, 0);
    endtask

    task automatic t_valid_pulse;
        lookup(MAC_A, got_acc);
        @(negedge clk);
        check("R2", "valid drops after one cycle", res_valid_o, 0);
        check("R2", "accept low without valid", res_accept_o, 0);
    endtask

    task automatic t_exact;
        set_station(0, MAC_A, 1'b1);
        set_station(15, MAC_B, 1'b1);
        set_station(5, MAC_C, 1'b0);
        lookup(MAC_A, got_acc);
        check("R3", "entry 0 match", got_acc, 1);
        lookup(MAC_B, got_acc);
        check("R3", "entry 15 match", got_acc, 1);
        lookup(MAC_A ^ 48'h0100_0000_0000, got_acc);
        check("R3", "byte 5 differs", got_acc, 0);
        lookup(MAC_A ^ 48'h0000_0000_0001, got_acc);
        check("R3", "byte 0 differs", got_acc, 0);
        lookup(MAC_C, got_acc);
        check("R4", "invalid entry ignored", got_acc, 0);
        check("R7", "exact hits not counted", mc_count_o, exp_cnt);
    endtask

    task automatic t_hash_modes;
        for (int m = 0; m < 4; m++) begin
            int idx;
            idx = hash_idx(MAC_H, m);
            set_ctl(1'b1, 2'(m));
            lookup(MAC_H, got_acc);
            check("R6", "clear bit rejects", got_acc, 0);
            wr(8'(8'h80 + (idx >> 5)), 32'(1) << (idx & 31));
            lookup(MAC_H, got_acc);
            check("R5", $sformatf("mode %0d index %0h accepts", m, idx), got_acc, 1);
            exp_cnt = sat(exp_cnt + 1);
            check("R7", "hash accept counted", mc_count_o, exp_cnt);
            wr(8'(8'h80 + (idx >> 5)), ~(32'(1) << (idx & 31)));
            lookup(MAC_H, got_acc);
            check("R6", "other bits of word do not accept", got_acc, 0);
            wr(8'(8'h80 + (idx >> 5)), 32'd0);
        end
    endtask

    task automatic t_gating;
        int idx;
        set_ctl(1'b1, 2'd3);
        idx = hash_idx(MAC_H, 3);
        wr(8'(8'h80 + (idx >> 5)), 32'(1) << (idx & 31));
        link_up_i = 1'b0;
        lookup(MAC_A, got_acc);
        check("R9", "link down exact", got_acc, 0);
        lookup(MAC_H, got_acc);
        check("R9", "link down hash", got_acc, 0);
        link_up_i = 1'b1;
        bus_master_i = 1'b0;
        lookup(MAC_H, got_acc);
        check("R9", "bus master off", got_acc, 0);
        bus_master_i = 1'b1;
        set_ctl(1'b0, 2'd3);
        lookup(MAC_A, got_acc);
        check("R9", "receive disabled", got_acc, 0);
        check("R9", "count frozen while blocked", mc_count_o, exp_cnt);
        set_ctl(1'b1, 2'd3);
        lookup(MAC_A, got_acc);
        check("R9", "reenabled exact", got_acc, 1);
    endtask

    task automatic t_same_cycle;
        wr(8'h06, MAC_D[31:0]);
        @(negedge clk);
        cfg_wr_en_i   = 1'b1;
        cfg_wr_addr_i = 8'h07;
        cfg_wr_data_i = {1'b1, 15'd0, MAC_D[47:32]};
        dst_vld_i     = 1'b1;
        dst_addr_i    = MAC_D;
        @(negedge clk);
        cfg_wr_en_i = 1'b0;
        dst_vld_i   = 1'b0;
        check("R10", "write not seen by same lookup", res_accept_o, 0);
        lookup(MAC_D, got_acc);
        check("R10", "write seen by next lookup", got_acc, 1);
    endtask

    task automatic t_saturate;
        for (int k = 0; k < 14; k++) begin
            lookup(MAC_H, got_acc);
            exp_cnt = sat(exp_cnt + 1);
            check("R8", $sformatf("count step %0d", k), mc_count_o, exp_cnt);
        end
        check("R8", "count held at max", mc_count_o, CNT_MAX);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_valid_pulse();
        t_exact();
        t_hash_modes();
        t_gating();
        t_same_cycle();
        t_saturate();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule